// File: doc/BRIEF.md
# Four-Channel Gated Edge-Count Frequency Meter

This block estimates the frequency of four digital tone lines. It counts falling edges over a fixed window of sampling ticks. Each raw line first passes through a two-flop synchroniser. A falling edge on the synchronised line sets a sticky pending flag for that channel. On every tick, each channel whose flag is set adds one to its edge counter, and then every flag is cleared.

A single gate down-counter serves all four channels. When a tick finds the gate at zero, each channel's counter is copied into its result register and the counter restarts. The gate then reloads, and a one-clock valid strobe announces the new results. With the default reload of 9999, a window lasts 10000 ticks. Converting counts to hertz is left to the consumer.

Top module: `tone_freq_meter`

## Requirements
- R1: While `rst` is high and after it is released, every result reads 0 and `result_vld` is 0 until the first snapshot.
- R2: A high-to-low transition on a raw input is counted. A low-to-high transition is not counted. A counter changes only on a tick, by at most one.
- R3: Any number of falling edges on a channel between two ticks add exactly one to that channel's count.
- R4: The gate loads RELOAD at reset and loses one on each tick where it is non-zero. The first snapshot happens on tick RELOAD+1 after reset, and later snapshots follow every RELOAD+1 ticks.
- R5: On a snapshot tick, each result takes the counter value from before that tick. The counter then restarts at 1 if that tick harvested an edge, otherwise at 0.
- R6: Counters and results are CW bits wide and wrap modulo 2^CW with no saturation.
- R7: `result_vld` is high for exactly the one clock that follows each snapshot tick.
- R8: An edge detected in the same clock as a tick is not lost. It stays pending and is counted on the next tick.
- R9: Clocks without a tick leave the counters and the gate unchanged. Results hold their value except on a snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sampling tick, one clock wide |
| tone_in | input | CH | Raw asynchronous tone lines |
| result | output | CH*CW | Latched counts, channel i at bits [i*CW +: CW] |
| result_vld | output | 1 | One-clock strobe after each snapshot |

## Verification
The bench runs the meter with a narrow counter (CW=6) and a short gate (RELOAD=79), so the windows are long enough to overflow. A window with one edge per tick then must read 80 mod 64 = 16, and a saturating counter would read 63 instead. Double edges between ticks must count once; a design that counted every edge would report double. Edges placed so that detection coincides with the tick must land in the next harvest; a design whose flag clear wins over the new edge would drop them and read low. Windows with rising edges only on return-to-high must read exactly the falling-edge count, and a design that is off by one tick at the gate would shift the window boundary and disagree with the model's split across snapshots.

// File: rtl/tone_freq_meter.sv
module tone_freq_meter #(
  parameter int CH     = 4,
  parameter int CW     = 16,
  parameter int GW     = 16,
  parameter int RELOAD = 9999
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [CH-1:0]      tone_in,
  output logic [CH*CW-1:0]   result,
  output logic               result_vld
);
  localparam logic [GW-1:0] GATE_INIT = GW'(RELOAD);

  logic [CH-1:0]    sync_a, sync_b, prev, pend;
  logic [GW-1:0]    gate;
  logic [CH*CW-1:0] cnt;

  wire [CH-1:0] fall = prev & ~sync_b;
  wire          snap = tick && (gate == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a     <= '0;
      sync_b     <= '0;
      prev       <= '0;
      pend       <= '0;
      gate       <= GATE_INIT;
      result_vld <= 1'b0;
    end else begin
      sync_a     <= tone_in;
      sync_b     <= sync_a;
      prev       <= sync_b;
      pend       <= (tick ? '0 : pend) | fall;
      result_vld <= snap;
      if (tick) gate <= snap ? GATE_INIT : gate - 1'b1;
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i*CW +: CW]    <= '0;
        result[i*CW +: CW] <= '0;
      end else if (tick) begin
        if (snap) begin
          result[i*CW +: CW] <= cnt[i*CW +: CW];
          cnt[i*CW +: CW]    <= CW'(pend[i]);
        end else begin
          cnt[i*CW +: CW]    <= cnt[i*CW +: CW] + CW'(pend[i]);
        end
      end
    end
  end
endmodule

module tone_freq_meter_chk #(
  parameter int CH     = 4,
  parameter int CW     = 16,
  parameter int GW     = 16,
  parameter int RELOAD = 9999
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [GW-1:0]    gate,
  input logic [CH*CW-1:0] cnt,
  input logic [CH*CW-1:0] result,
  input logic             result_vld,
  input logic [CH-1:0]    prev,
  input logic [CH-1:0]    sync_b,
  input logic [CH-1:0]    pend
);
  p_gate_dec_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && gate != '0) |=> gate == $past(gate) - 1'b1);
  p_gate_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && gate == '0) |=> gate == GW'(RELOAD));
  p_snap_copy_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && gate == '0) |=> result == $past(cnt));
  p_vld_reload_r7: assert property (@(posedge clk) disable iff (rst)
    result_vld |-> gate == GW'(RELOAD));
  p_cnt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cnt) && $stable(gate)));
  p_res_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !result_vld |-> $stable(result));
  for (genvar i = 0; i < CH; i++) begin : g_a
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
      (tick && gate != '0) |=> (cnt[i*CW +: CW] == $past(cnt[i*CW +: CW]) ||
                                cnt[i*CW +: CW] == $past(cnt[i*CW +: CW]) + CW'(1)));
    p_snap_restart_r5: assert property (@(posedge clk) disable iff (rst)
      (tick && gate == '0) |=> cnt[i*CW +: CW] <= CW'(1));
    p_pend_keep_r8: assert property (@(posedge clk) disable iff (rst)
      (tick && prev[i] && !sync_b[i]) |=> pend[i]);
  end
endmodule

bind tone_freq_meter tone_freq_meter_chk #(.CH(CH), .CW(CW), .GW(GW), .RELOAD(RELOAD)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .gate(gate), .cnt(cnt), .result(result),
  .result_vld(result_vld), .prev(prev), .sync_b(sync_b), .pend(pend)
);

// File: tb/tone_freq_meter_tb_top.sv
module tone_freq_meter_tb_top;
  localparam int CH = 4, CW = 6, GW = 16, R = 79, NWIN = 16;

  logic clk = 0, rst = 1, tick = 0;
  logic [CH-1:0] tone_in = '1;
  logic [CH*CW-1:0] result;
  logic result_vld;

  always #5 clk = ~clk;

  tone_freq_meter #(.CH(CH), .CW(CW), .GW(GW), .RELOAD(R)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .tone_in(tone_in),
    .result(result), .result_vld(result_vld));

  int checks = 0, fails = 0, snaps_seen = 0;
  bit done = 0;
  logic [CH*CW-1:0] expq[$];
  logic [CW-1:0] mcnt [CH];
  int mgate = R, mwin = 0;
  logic [CH-1:0] carry = '0, h;
  int mode [CH];
  logic [15:0] lfsr = 16'hACE1;
  bit prev_vld = 0;

  function automatic bit level(int m, int j);
    return !((m == 1 && (j == 1 || j == 2)) || (m == 2 && (j == 1 || j == 4)) ||
             (m == 3 && (j == 5 || j == 6)));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected snapshots when the strobe is seen
  always @(negedge clk) if (!rst) begin
    if (result_vld) begin
      checks++;
      if (prev_vld) begin
        fails++; $display("FAIL R7 strobe wider than one clock: got 1 expected 0");
      end
      if (expq.size() == 0) begin
        fails++; $display("FAIL R4 unexpected snapshot: got strobe expected none");
      end else begin
        logic [CH*CW-1:0] e;
        e = expq.pop_front();
        snaps_seen++;
        for (int i = 0; i < CH; i++) begin
          checks++;
          if (result[i*CW +: CW] !== e[i*CW +: CW]) begin
            fails++;
            $display("FAIL R5/R6 win %0d ch %0d: got %0d expected %0d", snaps_seen, i,
                     result[i*CW +: CW], e[i*CW +: CW]);
          end
        end
      end
    end
    prev_vld = result_vld;
  end

  initial begin
    #2_000_000;
    fails++; $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < CH; i++) mcnt[i] = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (result !== '0 || result_vld !== 1'b0) begin
      fails++; $display("FAIL R1 during reset: got %h/%b expected 0/0", result, result_vld);
    end
    rst = 0;
    repeat (6) @(negedge clk);
    checks++;
    if (result !== '0 || result_vld !== 1'b0) begin
      fails++; $display("FAIL R1 after reset: got %h/%b expected 0/0", result, result_vld);
    end
    while (mwin < NWIN) begin
      // plan the interval: 1 early edge (R2), 2 double edge (R3), 3 late edge on tick (R8)
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      for (int i = 0; i < CH; i++) begin
        case (mwin)
          1: mode[i] = 0;
          2: mode[i] = 2;
          3: mode[i] = 3;
          4: mode[i] = 1;
          default: mode[i] = int'(lfsr[2*i +: 2]);
        endcase
        h[i] = carry[i] || mode[i] == 1 || mode[i] == 2;
        carry[i] = (mode[i] == 3);
      end
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        for (int i = 0; i < CH; i++) tone_in[i] = level(mode[i], j);
        tick = (j == 7);
        if (j == 7) begin
          if (mgate == 0) begin
            logic [CH*CW-1:0] e;
            for (int i = 0; i < CH; i++) begin
              e[i*CW +: CW] = mcnt[i];
              mcnt[i] = CW'(h[i]);
            end
            expq.push_back(e);
            mgate = R;
            mwin++;
          end else begin
            for (int i = 0; i < CH; i++) mcnt[i] = mcnt[i] + CW'(h[i]);
            mgate--;
          end
        end
      end
    end
    @(negedge clk); tick = 0;
    repeat (20) @(negedge clk);
    checks++;
    if (expq.size() != 0 || snaps_seen != NWIN) begin
      fails++; $display("FAIL R4 snapshot count: got %0d expected %0d", snaps_seen, NWIN);
    end
    checks++;
    if (result_vld !== 1'b0) begin
      fails++; $display("FAIL R7 idle strobe: got %b expected 0", result_vld);
    end
    finish_run();
  end
endmodule